// File: doc/BRIEF.md
# Channelized Host Register Port with Wait Handshake

This block is the slave side of the host register port of a multi-channel serial bus controller. The host reaches every register through a 9-bit address. That address carries the channel number, whether the receive or the transmit half is meant, a register index and a byte-lane index. Reads and writes use active-low strobes. A data-in bus and a separate data-out bus share one configurable width of 8, 16 or 32 bits.

The block holds an 8-bit control register for each half of each channel, a status register for each half, and a label register for each receive channel. A 32-bit transmit word is built from several narrow writes and is handed to the transmit queue as one push. A 32-bit receive word is captured whole on its first narrow read, so the remaining lanes come from the same word. Every access is stretched by a wait output. A per-channel interrupt flag tells the host that a new receive word is waiting. The queues themselves are outside this block and appear only as per-channel strobes and word buses.

Top module: `chan_regport`

## Requirements
- R1: The latched address decodes as channel = addr[8:5], half = addr[4] (0 receive, 1 transmit), register = addr[3:2] (0 data, 1 control, 2 status, 3 label on the receive half only; transmit register 3 reads 0 and ignores writes), lane = addr[1:0] taken modulo 32/DW.
- R2: When a strobe (host_ren_n or host_wen_n low) is sampled at an edge while the port is idle, the block latches the address and write data, and host_wait is high for exactly WAIT_CYC (2) cycles after that edge. host_wait then stays low for as long as the strobe is held. A new access starts only after both strobes have been sampled high once.
- R3: The control registers (both halves) and the receive label register are 8 bits wide. Each is read or written in a single access: a write takes host_wdata[7:0], and a read returns the value in bits 7:0 with the upper bits zero. The lane bits are ignored for these registers. host_rdata changes only at the edge where host_wait falls on a read.
- R4: A transmit data write stores DW bits at bit lane*DW of the channel's 32-bit holding word. A write to lane 32/DW-1 also pulses txq_push[ch] for one cycle and loads txq_word[ch] with the completed word. A transmit data read returns the held lane.
- R5: A read of receive data lane 0 returns rxq_word[ch][DW-1:0] as it is at completion, captures the whole rxq_word[ch], and pulses rxq_pop[ch] for one cycle if rxq_avail[ch] is high. Reads of lanes 1 to 32/DW-1 return the captured word even if rxq_word has changed since.
- R6: Receive status reads {6'b0, irq flag, rxq_avail[ch]}; transmit status reads {7'b0, txq_full[ch]}. Writes to either status register and to receive data have no effect.
- R7: A channel's interrupt flag sets one edge after rxq_avail[ch] rises. It clears at the completion of a read of that channel's receive status, which still returns the flag as set; if a set and a clear fall on the same edge, the set wins. host_irq is the active-high OR of all flags.
- R8: An address whose channel field is NCH or higher (with NCH of 8 or fewer this includes every address with addr[8]=1) reads 0 and changes nothing, but it still completes the handshake.
- R9: If both strobes are low when an access starts, the access is a write.
- R10: While reset is high and after it, host_rdata, host_wait, host_irq, txq_push, rxq_pop, txq_word and all registers are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_ren_n | input | 1 | Read strobe, active low |
| host_wen_n | input | 1 | Write strobe, active low |
| host_addr | input | 9 | Channel, half, register and lane address |
| host_wdata | input | DW | Write data from host |
| host_rdata | output | DW | Read data to host, registered |
| host_wait | output | 1 | High while the current access is completing |
| host_irq | output | 1 | Interrupt, active high |
| rxq_word | input | NCH*32 | Head word of each receive queue |
| rxq_avail | input | NCH | Receive queue holds a word |
| rxq_pop | output | NCH | One-cycle pop strobe per receive queue |
| txq_full | input | NCH | Transmit queue full flag, shown in status |
| txq_push | output | NCH | One-cycle push strobe per transmit queue |
| txq_word | output | NCH*32 | Last committed transmit word per channel |

## Verification
The control and label registers are written with distinct values on neighbouring channels and halves. Reading them back, including with non-zero lane bits, separates a correct decode of channel, half and register from an aliased one. The transmit word is written lane by lane with a distinct byte in each lane. This shows that the push happens only on the last lane and that the bytes land in order. For the receive side, the head word is changed between the lane 0 read and the later lane reads, which shows whether the word was captured. Out-of-range channels, addresses with the top bit set, writes to read-only registers, a strobe held long after wait drops, and both strobes low together are each followed by a read-back through the port. A behavioural model also predicts wait, read data, interrupt, push, pop and the transmit words on every cycle.

// File: rtl/crp_pkg.sv
package crp_pkg;
  localparam int ADDR_W = 9;
  localparam int WORD_W = 32;

  typedef enum logic [1:0] {
    RS_DATA  = 2'd0,
    RS_CTRL  = 2'd1,
    RS_STAT  = 2'd2,
    RS_LABEL = 2'd3
  } rsel_e;

  typedef struct packed {
    logic [3:0] chan;
    logic       is_tx;
    rsel_e      rsel;
    logic [1:0] lane;
  } afield_t;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_WAIT = 2'd1,
    PH_HOLD = 2'd2
  } phase_e;
endpackage

// File: rtl/crp_addr_decode.sv
module crp_addr_decode
  import crp_pkg::*;
#(
  parameter int NCH = 4
) (
  input  logic [ADDR_W-1:0] addr,
  output afield_t           fld,
  output logic              in_range
);
  always_comb begin
    fld.chan  = addr[8:5];
    fld.is_tx = addr[4];
    fld.rsel  = rsel_e'(addr[3:2]);
    fld.lane  = addr[1:0];
    in_range  = (int'(addr[8:5]) < NCH);
  end
endmodule

// File: rtl/crp_handshake.sv
module crp_handshake
  import crp_pkg::*;
#(
  parameter int WAIT_CYC = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic ren_n,
  input  logic wen_n,
  output logic start,
  output logic fire,
  output logic busy_wait,
  output logic is_write
);
  localparam int CW = $clog2(WAIT_CYC + 1);

  phase_e        ph;
  logic [CW-1:0] cnt;
  logic          strobe;

  assign strobe = !ren_n || !wen_n;
  assign start  = (ph == PH_IDLE) && strobe;
  assign fire   = (ph == PH_WAIT) && (cnt == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      ph        <= PH_IDLE;
      cnt       <= '0;
      busy_wait <= 1'b0;
      is_write  <= 1'b0;
    end else begin
      case (ph)
        PH_IDLE: if (strobe) begin
          ph        <= PH_WAIT;
          cnt       <= CW'(WAIT_CYC - 1);
          busy_wait <= 1'b1;
          is_write  <= !wen_n;
        end
        PH_WAIT: if (cnt == '0) begin
          ph        <= PH_HOLD;
          busy_wait <= 1'b0;
        end else begin
          cnt <= cnt - CW'(1);
        end
        PH_HOLD: if (!strobe) ph <= PH_IDLE;
        default: ph <= PH_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/crp_chan_bank.sv
module crp_chan_bank
  import crp_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              fire,
  input  logic              is_write,
  input  logic              sel,
  input  logic              is_tx,
  input  rsel_e             rsel,
  input  logic [1:0]        lane,
  input  logic [DW-1:0]     wdata,
  input  logic [WORD_W-1:0] rx_word,
  input  logic              rx_avail,
  input  logic              tx_full,
  output logic [DW-1:0]     rdata,
  output logic              tx_push,
  output logic [WORD_W-1:0] tx_word,
  output logic              rx_pop,
  output logic              irq_flag
);
  localparam int LANES = WORD_W / DW;

  logic [7:0]        ctrl_rx, ctrl_tx, label_q;
  logic [WORD_W-1:0] tx_hold, snap, merged;
  logic              avail_q;
  logic [1:0]        lane_m;
  logic              last_lane, do_wr, do_rd, stat_clr;

  assign lane_m    = lane & 2'(LANES - 1);
  assign last_lane = (lane_m == 2'(LANES - 1));
  assign do_wr     = fire && sel && is_write;
  assign do_rd     = fire && sel && !is_write;
  assign stat_clr  = do_rd && !is_tx && (rsel == RS_STAT);

  always_comb begin
    merged = tx_hold;
    merged[lane_m*DW +: DW] = wdata;
  end

  always_comb begin
    rdata = '0;
    case (rsel)
      RS_DATA: begin
        if (is_tx)             rdata = tx_hold[lane_m*DW +: DW];
        else if (lane_m == '0) rdata = rx_word[DW-1:0];
        else                   rdata = snap[lane_m*DW +: DW];
      end
      RS_CTRL:  rdata[7:0] = is_tx ? ctrl_tx : ctrl_rx;
      RS_STAT:  rdata[7:0] = is_tx ? {7'b0, tx_full} : {6'b0, irq_flag, rx_avail};
      RS_LABEL: if (!is_tx) rdata[7:0] = label_q;
      default:  rdata = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_rx  <= '0;
      ctrl_tx  <= '0;
      label_q  <= '0;
      tx_hold  <= '0;
      snap     <= '0;
      tx_word  <= '0;
      tx_push  <= 1'b0;
      rx_pop   <= 1'b0;
      avail_q  <= 1'b0;
      irq_flag <= 1'b0;
    end else begin
      tx_push  <= 1'b0;
      rx_pop   <= 1'b0;
      avail_q  <= rx_avail;
      irq_flag <= (rx_avail && !avail_q) || (irq_flag && !stat_clr);
      if (do_wr) begin
        case (rsel)
          RS_DATA: if (is_tx) begin
            tx_hold <= merged;
            if (last_lane) begin
              tx_push <= 1'b1;
              tx_word <= merged;
            end
          end
          RS_CTRL: begin
            if (is_tx) ctrl_tx <= wdata[7:0];
            else       ctrl_rx <= wdata[7:0];
          end
          RS_LABEL: if (!is_tx) label_q <= wdata[7:0];
          default: ;
        endcase
      end
      if (do_rd && !is_tx && (rsel == RS_DATA) && (lane_m == '0)) begin
        snap   <= rx_word;
        rx_pop <= rx_avail;
      end
    end
  end
endmodule

// File: rtl/chan_regport.sv
module chan_regport
  import crp_pkg::*;
#(
  parameter int NCH      = 4,
  parameter int DW       = 8,
  parameter int WAIT_CYC = 2
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  host_ren_n,
  input  logic                  host_wen_n,
  input  logic [ADDR_W-1:0]     host_addr,
  input  logic [DW-1:0]         host_wdata,
  output logic [DW-1:0]         host_rdata,
  output logic                  host_wait,
  output logic                  host_irq,
  input  logic [NCH*WORD_W-1:0] rxq_word,
  input  logic [NCH-1:0]        rxq_avail,
  output logic [NCH-1:0]        rxq_pop,
  input  logic [NCH-1:0]        txq_full,
  output logic [NCH-1:0]        txq_push,
  output logic [NCH*WORD_W-1:0] txq_word
);
  logic              start, fire, is_write, in_range;
  logic [ADDR_W-1:0] addr_q;
  logic [DW-1:0]     wdata_q, rd_sel;
  afield_t           fld;
  logic [DW-1:0]     bank_rd [NCH];
  logic [NCH-1:0]    flags;

  crp_handshake #(.WAIT_CYC(WAIT_CYC)) u_hs (
    .clk(clk), .rst(rst), .ren_n(host_ren_n), .wen_n(host_wen_n),
    .start(start), .fire(fire), .busy_wait(host_wait), .is_write(is_write)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q  <= '0;
      wdata_q <= '0;
    end else if (start) begin
      addr_q  <= host_addr;
      wdata_q <= host_wdata;
    end
  end

  crp_addr_decode #(.NCH(NCH)) u_dec (
    .addr(addr_q), .fld(fld), .in_range(in_range)
  );

  for (genvar g = 0; g < NCH; g++) begin : g_chan
    crp_chan_bank #(.DW(DW)) u_bank (
      .clk(clk), .rst(rst), .fire(fire), .is_write(is_write),
      .sel(in_range && (fld.chan == 4'(g))),
      .is_tx(fld.is_tx), .rsel(fld.rsel), .lane(fld.lane),
      .wdata(wdata_q),
      .rx_word(rxq_word[g*WORD_W +: WORD_W]), .rx_avail(rxq_avail[g]),
      .tx_full(txq_full[g]),
      .rdata(bank_rd[g]), .tx_push(txq_push[g]),
      .tx_word(txq_word[g*WORD_W +: WORD_W]),
      .rx_pop(rxq_pop[g]), .irq_flag(flags[g])
    );
  end

  always_comb begin
    rd_sel = '0;
    for (int i = 0; i < NCH; i++)
      if (in_range && (fld.chan == 4'(i))) rd_sel = bank_rd[i];
  end

  always_ff @(posedge clk) begin
    if (rst)                   host_rdata <= '0;
    else if (fire && !is_write) host_rdata <= rd_sel;
  end

  assign host_irq = |flags;
endmodule

// File: rtl/crp_checker.sv
module crp_checker #(
  parameter int NCH      = 4,
  parameter int DW       = 8,
  parameter int WAIT_CYC = 2
) (
  input logic           clk,
  input logic           rst,
  input logic           host_ren_n,
  input logic           host_wen_n,
  input logic           host_wait,
  input logic [DW-1:0]  host_rdata,
  input logic           host_irq,
  input logic [NCH-1:0] rxq_avail,
  input logic [NCH-1:0] rxq_pop,
  input logic [NCH-1:0] txq_push
);
  logic [15:0] wrun;

  always_ff @(posedge clk) begin
    if (rst)            wrun <= '0;
    else if (host_wait) wrun <= (wrun == 16'hFFFF) ? wrun : wrun + 16'd1;
    else                wrun <= '0;
  end

  assert_wait_len_R2: assert property (@(posedge clk) disable iff (rst)
    int'(wrun) <= WAIT_CYC);

  assert_wait_cause_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(host_wait) |-> $past(!host_ren_n || !host_wen_n));

  assert_rdata_hold_R3: assert property (@(posedge clk) disable iff (rst)
    !$fell(host_wait) |-> $stable(host_rdata));

  assert_push_single_R4: assert property (@(posedge clk) disable iff (rst)
    $onehot0(txq_push));

  assert_push_at_done_R4: assert property (@(posedge clk) disable iff (rst)
    (|txq_push) |-> (!host_wait && $past(host_wait)));

  assert_pop_single_R5: assert property (@(posedge clk) disable iff (rst)
    $onehot0(rxq_pop));

  assert_pop_at_done_R5: assert property (@(posedge clk) disable iff (rst)
    (|rxq_pop) |-> (!host_wait && $past(host_wait)));

  assert_irq_cause_R7: assert property (@(posedge clk) disable iff (rst)
    $rose(host_irq) |-> $past(|rxq_avail));
endmodule

bind chan_regport crp_checker #(.NCH(NCH), .DW(DW), .WAIT_CYC(WAIT_CYC)) u_chk (
  .clk(clk), .rst(rst), .host_ren_n(host_ren_n), .host_wen_n(host_wen_n),
  .host_wait(host_wait), .host_rdata(host_rdata), .host_irq(host_irq),
  .rxq_avail(rxq_avail), .rxq_pop(rxq_pop), .txq_push(txq_push)
);

// File: tb/test_chan_regport.sv
module test_chan_regport;
  localparam int NCH = 4, DW = 8, WAIT_CYC = 2, LANES = 32 / DW;

  logic clk = 1'b0, rst = 1'b1, ren_n = 1'b1, wen_n = 1'b1;
  logic [8:0]        addr = '0;
  logic [DW-1:0]     wdata = '0;
  logic [DW-1:0]     rdata;
  logic              hwait, irq;
  logic [NCH*32-1:0] rx_word = '0;
  logic [NCH*32-1:0] tx_word;
  logic [NCH-1:0]    rx_avail = '0, tx_full = '0, tx_push, rx_pop;

  always #4 clk = ~clk;

  chan_regport #(.NCH(NCH), .DW(DW), .WAIT_CYC(WAIT_CYC)) i_chan_regport (
    .clk(clk), .rst(rst), .host_ren_n(ren_n), .host_wen_n(wen_n),
    .host_addr(addr), .host_wdata(wdata), .host_rdata(rdata),
    .host_wait(hwait), .host_irq(irq),
    .rxq_word(rx_word), .rxq_avail(rx_avail), .rxq_pop(rx_pop),
    .txq_full(tx_full), .txq_push(tx_push), .txq_word(tx_word)
  );

  int vectors = 0, misc = 0, cyc = 0;
  bit done = 0;

  task automatic cmp(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      misc++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // behavioural reference model
  int m_ph = 0, m_cnt = 0, m_ch, m_rs, m_ln;
  bit m_wr = 0, m_tx;
  logic [8:0]     m_addr = '0;
  logic [DW-1:0]  m_wd = '0;
  logic [7:0]     m_crx [NCH], m_ctx [NCH], m_lab [NCH];
  logic [31:0]    m_txh [NCH], m_snap [NCH], m_txw [NCH];
  logic [NCH-1:0] m_flag = '0, m_rdyq = '0, m_clr;
  logic           e_wait = 0, e_irq = 0;
  logic [DW-1:0]  e_rdata = '0;
  logic [NCH-1:0] e_push = '0, e_pop = '0;

  function automatic logic [DW-1:0] m_read(int ch, bit tx, int rs, int ln);
    logic [DW-1:0] v;
    v = '0;
    case (rs)
      0: if (tx) v = m_txh[ch][ln*DW +: DW];
         else if (ln == 0) v = rx_word[ch*32 +: DW];
         else v = m_snap[ch][ln*DW +: DW];
      1: v[7:0] = tx ? m_ctx[ch] : m_crx[ch];
      2: v[7:0] = tx ? {7'b0, tx_full[ch]} : {6'b0, m_flag[ch], rx_avail[ch]};
      default: if (!tx) v[7:0] = m_lab[ch];
    endcase
    return v;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_ph = 0; m_cnt = 0; e_wait = 0; e_irq = 0; e_rdata = '0;
      e_push = '0; e_pop = '0; m_flag = '0; m_rdyq = '0;
      for (int i = 0; i < NCH; i++) begin
        m_crx[i] = '0; m_ctx[i] = '0; m_lab[i] = '0;
        m_txh[i] = '0; m_snap[i] = '0; m_txw[i] = '0;
      end
    end else begin
      e_push = '0; e_pop = '0; m_clr = '0;
      if (m_ph == 1 && m_cnt == 0) begin
        e_wait = 0; m_ph = 2;
        m_ch = int'(m_addr[8:5]); m_tx = m_addr[4];
        m_rs = int'(m_addr[3:2]); m_ln = int'(m_addr[1:0]) % LANES;
        if (m_ch < NCH) begin
          if (!m_wr) begin
            e_rdata = m_read(m_ch, m_tx, m_rs, m_ln);
            if (!m_tx && m_rs == 2) m_clr[m_ch] = 1'b1;
            if (!m_tx && m_rs == 0 && m_ln == 0) begin
              m_snap[m_ch] = rx_word[m_ch*32 +: 32];
              e_pop[m_ch] = rx_avail[m_ch];
            end
          end else begin
            if (m_rs == 1) begin
              if (m_tx) m_ctx[m_ch] = m_wd[7:0]; else m_crx[m_ch] = m_wd[7:0];
            end else if (m_rs == 3 && !m_tx) m_lab[m_ch] = m_wd[7:0];
            else if (m_rs == 0 && m_tx) begin
              m_txh[m_ch][m_ln*DW +: DW] = m_wd;
              if (m_ln == LANES - 1) begin e_push[m_ch] = 1'b1; m_txw[m_ch] = m_txh[m_ch]; end
            end
          end
        end else if (!m_wr) e_rdata = '0;
      end else if (m_ph == 1) m_cnt--;
      else if (m_ph == 0 && (!ren_n || !wen_n)) begin
        m_ph = 1; m_cnt = WAIT_CYC - 1; e_wait = 1; m_wr = !wen_n;
        m_addr = addr; m_wd = wdata;
      end else if (m_ph == 2 && ren_n && wen_n) m_ph = 0;
      for (int i = 0; i < NCH; i++) begin
        m_flag[i] = (rx_avail[i] && !m_rdyq[i]) || (m_flag[i] && !m_clr[i]);
        m_rdyq[i] = rx_avail[i];
      end
      e_irq = |m_flag;
    end
  end

  always @(negedge clk) begin
    if (!rst && !done) begin
      cmp("R2 wait per cycle", 32'(hwait), 32'(e_wait));
      cmp("R1 rdata per cycle", 32'(rdata), 32'(e_rdata));
      cmp("R7 irq per cycle", 32'(irq), 32'(e_irq));
      cmp("R4 push per cycle", 32'(tx_push), 32'(e_push));
      cmp("R5 pop per cycle", 32'(rx_pop), 32'(e_pop));
      for (int i = 0; i < NCH; i++) cmp("R4 tx word per cycle", tx_word[i*32 +: 32], m_txw[i]);
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      misc++;
      $display("FAIL R2 watchdog: actual hung expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misc);
      $finish;
    end
  end

  task automatic acc(input bit wr, input logic [8:0] a, input logic [31:0] d,
                     input int hold, output logic [31:0] rd, output int wcyc);
    @(negedge clk);
    addr = a; wdata = d[DW-1:0];
    if (wr) wen_n = 1'b0; else ren_n = 1'b0;
    wcyc = 0;
    @(negedge clk);
    while (hwait) begin wcyc++; @(negedge clk); end
    rd = 32'(rdata);
    for (int k = 0; k < hold; k++) begin
      @(negedge clk);
      cmp("R2 wait stays low while strobe held", 32'(hwait), 32'h0);
    end
    ren_n = 1'b1; wen_n = 1'b1;
    @(negedge clk);
  endtask

  logic [31:0] rd;
  int wc;

  initial begin
    repeat (3) @(negedge clk);
    cmp("R10 reset rdata", 32'(rdata), 0);
    cmp("R10 reset wait", 32'(hwait), 0);
    cmp("R10 reset irq", 32'(irq), 0);
    cmp("R10 reset push", 32'(tx_push), 0);
    cmp("R10 reset tx word", tx_word[31:0], 0);
    rst = 1'b0;

    acc(1, 9'h024, 32'hA5, 0, rd, wc);
    cmp("R2 wait length", 32'(wc), 32'(WAIT_CYC));
    acc(1, 9'h034, 32'h3C, 0, rd, wc);
    acc(1, 9'h04C, 32'h77, 0, rd, wc);
    acc(0, 9'h024, 0, 0, rd, wc);
    cmp("R3 rx ctrl ch1", rd, 32'hA5);
    cmp("R2 read wait length", 32'(wc), 32'(WAIT_CYC));
    acc(0, 9'h034, 0, 0, rd, wc);
    cmp("R3 tx ctrl ch1", rd, 32'h3C);
    acc(0, 9'h04C, 0, 0, rd, wc);
    cmp("R3 label ch2", rd, 32'h77);
    acc(0, 9'h027, 0, 0, rd, wc);
    cmp("R3 lane bits ignored on ctrl", rd, 32'hA5);
    acc(0, 9'h044, 0, 0, rd, wc);
    cmp("R1 ctrl ch2 distinct from label", rd, 32'h00);
    acc(0, 9'h05C, 0, 0, rd, wc);
    cmp("R1 tx register 3 reads zero", rd, 32'h00);

    for (int l = 0; l < LANES; l++) begin
      acc(1, 9'h070 + 9'(l), 32'(8'h11 * (l + 1)), 0, rd, wc);
      if (l == LANES - 2) cmp("R4 no push before last lane", tx_word[3*32 +: 32], 0);
    end
    cmp("R4 committed word ch3", tx_word[3*32 +: 32], 32'h44332211);
    acc(0, 9'h071, 0, 0, rd, wc);
    cmp("R4 tx lane readback", rd, 32'h22);

    @(negedge clk);
    rx_word[31:0] = 32'hDEADBEEF; rx_avail[0] = 1'b1;
    @(negedge clk);
    cmp("R7 irq after avail rise", 32'(irq), 1);
    acc(0, 9'h000, 0, 0, rd, wc);
    cmp("R5 lane0 live", rd, 32'hEF);
    rx_word[31:0] = 32'h01234567;
    acc(0, 9'h001, 0, 0, rd, wc);
    cmp("R5 snapshot lane1", rd, 32'hBE);
    acc(0, 9'h002, 0, 0, rd, wc);
    cmp("R5 snapshot lane2", rd, 32'hAD);
    acc(0, 9'h003, 0, 0, rd, wc);
    cmp("R5 snapshot lane3", rd, 32'hDE);
    acc(0, 9'h008, 0, 0, rd, wc);
    cmp("R6 rx status with flag", rd, 32'h03);
    cmp("R7 irq cleared by status read", 32'(irq), 0);
    acc(0, 9'h008, 0, 0, rd, wc);
    cmp("R7 status after clear", rd, 32'h01);
    acc(1, 9'h008, 32'hFF, 0, rd, wc);
    acc(0, 9'h008, 0, 0, rd, wc);
    cmp("R6 status write ignored", rd, 32'h01);
    acc(1, 9'h001, 32'h55, 0, rd, wc);
    acc(0, 9'h001, 0, 0, rd, wc);
    cmp("R6 rx data write ignored", rd, 32'hBE);

    @(negedge clk);
    tx_full[2] = 1'b1;
    acc(0, 9'h058, 0, 0, rd, wc);
    cmp("R6 tx status full", rd, 32'h01);

    acc(1, 9'h0A4, 32'h99, 0, rd, wc);
    acc(0, 9'h0A4, 0, 0, rd, wc);
    cmp("R8 out-of-range read zero", rd, 32'h00);
    acc(0, 9'h024, 0, 0, rd, wc);
    cmp("R8 no alias into ch1", rd, 32'hA5);
    acc(1, 9'h124, 32'h66, 0, rd, wc);
    acc(0, 9'h024, 0, 0, rd, wc);
    cmp("R8 top address bit write ignored", rd, 32'hA5);
    acc(0, 9'h124, 0, 0, rd, wc);
    cmp("R8 top address bit read zero", rd, 32'h00);

    @(negedge clk);
    addr = 9'h024; wdata = 8'h5A; ren_n = 1'b0; wen_n = 1'b0;
    @(negedge clk);
    while (hwait) @(negedge clk);
    ren_n = 1'b1; wen_n = 1'b1;
    @(negedge clk);
    acc(0, 9'h024, 0, 0, rd, wc);
    cmp("R9 both strobes act as write", rd, 32'h5A);

    acc(1, 9'h034, 32'h81, 4, rd, wc);
    acc(0, 9'h034, 0, 3, rd, wc);
    cmp("R2 long hold single access", rd, 32'h81);

    repeat (3) @(negedge clk);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misc);
    $finish;
  end
endmodule